// File: doc/BRIEF.md
# Dual-Convention Host Register Interface

This block sits on the peripheral side of an asynchronous parallel host bus. It gives a processor read and write access to eight 32-bit configuration registers. A static mode input chooses how two shared strobe pins are read. In split mode they are separate active-low read and write pulses. In direction mode one pin gives the transfer direction and the other is an active-low data strobe that qualifies the access. Chip select is active low and gates everything.

The block samples chip select and both strobes through two-flop synchronizers on its own clock. A write is committed one cycle after the synchronized write strobe is seen to release. It uses the address and data latched while the raw strobe was still active, so the host may drop its data soon after the strobe edge.

Read data comes from a registered multiplexer. The pad output enable is decoded combinationally from the raw pins, so the bus is released as soon as the host lets go. The data bus is presented as separate in, out and enable lines, and the pad ring combines them into one bidirectional bus.

Register 6 holds interrupt enables. Register 7 holds sticky interrupt status: bits are set by event pulses and cleared by writing ones. The active-low interrupt line is asserted while any enabled status bit is set.

Top module: `cfg_bus_slave`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register reads as zero, `data_oe` is 0 and `irq_n` is 1.
- R2: With `mode_sel`=0 (split mode), a write happens while `cs_n`=0 and `strb_b_n` pulses low. On release of `strb_b_n`, register `addr[2:0]` takes the data that was on `data_i` while the strobe was low. The new value is readable 4 clock cycles after the release.
- R3: With `mode_sel`=1 (direction mode), a write is `cs_n`=0, `strb_a_n`=0 (write direction) and a low pulse on `strb_b_n`. It commits on release of `strb_b_n`, with the same latency as R2.
- R4: With `mode_sel`=0, while `cs_n`=0 and `strb_a_n`=0, `data_oe` is 1. Within 3 clock cycles of the strobe going low, `data_o` carries the register selected by `addr`.
- R5: With `mode_sel`=1, while `cs_n`=0, `strb_b_n`=0 and `strb_a_n`=1, `data_oe` is 1 and `data_o` carries the addressed register within 3 clock cycles.
- R6: In every other pin state `data_oe` is 0, and it drops in the same cycle that `cs_n` rises, with no clock edge needed.
- R7: Strobe activity while `cs_n`=1 changes no register.
- R8: An address above 7 (any of `addr[15:3]` set) reads as zero, and a write to it changes no register, including the one whose index matches the low bits.
- R9: In register 7, a bit is set by a high cycle on the matching `evt_set` bit. A write clears each bit where the write data holds a 1 and leaves the others. A set in the same cycle as a clear wins.
- R10: `irq_n` is 0 exactly while some bit is 1 in both register 7 and register 6.
- R11: Read-direction accesses never write. In split mode this is a `strb_a_n` pulse. In direction mode it is a `strb_b_n` pulse with `strb_a_n`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Strobe convention: 0 split, 1 direction/strobe |
| cs_n | input | 1 | Active-low chip select |
| strb_a_n | input | 1 | Read strobe (split) or read-not-write (direction) |
| strb_b_n | input | 1 | Write strobe (split) or data strobe (direction) |
| addr | input | 16 | Register address |
| data_i | input | 32 | Write data from the pad |
| data_o | output | 32 | Read data to the pad |
| data_oe | output | 1 | Pad drive enable for read data |
| evt_set | input | 32 | Interrupt event pulses into register 7 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A write commits on the third rising clock edge after the write strobe is raised: two synchronizer stages, then the edge detect. The bench therefore waits four falling edges after the release before reading back.

Read data sits behind one register stage fed by the address, which is set a cycle before the strobe. The bench samples `data_o` on the third falling edge after the strobe goes low, matching the host's sampling point.

`data_oe` and `irq_n` are combinational from pins and register state. They are checked just after the pin change, or once a write has settled.

// File: rtl/cfg_bus_pkg.sv
package cfg_bus_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int NREG   = 8;

  typedef enum logic { MODE_SPLIT = 1'b0, MODE_DIRSTROBE = 1'b1 } bus_mode_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } strobe_t;

  // Turn raw pin levels into read/write intent for the selected convention.
  function automatic strobe_t decode_strobes(input logic mode, input logic cs_n,
                                             input logic a_n, input logic b_n);
    strobe_t s;
    if (bus_mode_e'(mode) == MODE_DIRSTROBE) begin
      s.rd = !cs_n && !b_n && a_n;
      s.wr = !cs_n && !b_n && !a_n;
    end else begin
      s.rd = !cs_n && !a_n;
      s.wr = !cs_n && !b_n;
    end
    return s;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/cfg_strobe_decode.sv
module cfg_strobe_decode
  import cfg_bus_pkg::*;
#(
  parameter int ADDR_W = cfg_bus_pkg::ADDR_W,
  parameter int DATA_W = cfg_bus_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              cs_n,
  input  logic              strb_a_n,
  input  logic              strb_b_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_raw,
  output logic              cs_sync_act,
  output logic              commit,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  strobe_t raw_s, syn_s;
  logic [2:0] pins_s;
  logic       wr_s_q;

  assign raw_s  = decode_strobes(mode_sel, cs_n, strb_a_n, strb_b_n);
  assign rd_raw = raw_s.rd;

  cfg_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, strb_a_n, strb_b_n}),
    .q    (pins_s)
  );

  assign syn_s       = decode_strobes(mode_sel, pins_s[2], pins_s[1], pins_s[0]);
  assign cs_sync_act = !pins_s[2];

  // Latch address/data on every cycle the raw write strobe is still active.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
      wr_s_q   <= 1'b0;
    end else begin
      wr_s_q <= syn_s.wr;
      if (raw_s.wr) begin
        cap_addr <= addr;
        cap_data <= data_i;
      end
    end
  end

  assign commit = wr_s_q && !syn_s.wr;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NREG     = 8,
  parameter int IEN_IDX  = NREG - 2,
  parameter int STAT_IDX = NREG - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] evt_set,
  output logic [DATA_W-1:0] rd_q,
  output logic [DATA_W-1:0] irq_status,
  output logic [DATA_W-1:0] irq_enable,
  output logic              irq_n
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NREG - 1);

  logic [DATA_W-1:0] regs [NREG];

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return a <= LAST_ADDR;
  endfunction

  function automatic logic [DATA_W-1:0] w1c_next(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] clr,
                                                 input logic [DATA_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = commit && is_mapped(waddr) && (waddr[IDX_W-1:0] == IDX_W'(i));
    if (i == STAT_IDX) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= '0;
        else        regs[i] <= w1c_next(regs[i], hit ? wdata : '0, evt_set);
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs[i] <= '0;
        else if (hit) regs[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_q <= '0;
    else if (is_mapped(raddr)) rd_q <= regs[raddr[IDX_W-1:0]];
    else                       rd_q <= '0;
  end

  assign irq_status = regs[STAT_IDX];
  assign irq_enable = regs[IEN_IDX];
  assign irq_n      = ~|(irq_status & irq_enable);
endmodule

// File: rtl/cfg_bus_slave.sv
module cfg_bus_slave #(
  parameter int ADDR_W = cfg_bus_pkg::ADDR_W,
  parameter int DATA_W = cfg_bus_pkg::DATA_W,
  parameter int NREG   = cfg_bus_pkg::NREG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              cs_n,
  input  logic              strb_a_n,
  input  logic              strb_b_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  input  logic [DATA_W-1:0] evt_set,
  output logic              irq_n
);
  // Named internal events, visible to the bound checker.
  logic              commit;
  logic              cs_sync_act;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] irq_status;
  logic [DATA_W-1:0] irq_enable;

  cfg_strobe_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .cs_n       (cs_n),
    .strb_a_n   (strb_a_n),
    .strb_b_n   (strb_b_n),
    .addr       (addr),
    .data_i     (data_i),
    .rd_raw     (data_oe),
    .cs_sync_act(cs_sync_act),
    .commit     (commit),
    .cap_addr   (cap_addr),
    .cap_data   (cap_data)
  );

  cfg_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .waddr     (cap_addr),
    .wdata     (cap_data),
    .raddr     (addr),
    .evt_set   (evt_set),
    .rd_q      (data_o),
    .irq_status(irq_status),
    .irq_enable(irq_enable),
    .irq_n     (irq_n)
  );
endmodule

// File: rtl/cfg_bus_slave_chk.sv
module cfg_bus_slave_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NREG   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              data_oe,
  input logic              commit,
  input logic              cs_sync_act,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [DATA_W-1:0] cap_data,
  input logic [DATA_W-1:0] evt_set,
  input logic [DATA_W-1:0] irq_status,
  input logic [DATA_W-1:0] irq_enable
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NREG - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NREG - 1);

  p_release_on_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !data_oe);

  p_commit_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_commit_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(cs_sync_act));

  p_status_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cap_addr == STAT_ADDR && evt_set == '0)
      |=> irq_status == ($past(irq_status) & ~$past(cap_data)));

  p_unmapped_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cap_addr > LAST_ADDR && evt_set == '0)
      |=> ($stable(irq_status) && $stable(irq_enable)));
endmodule

bind cfg_bus_slave cfg_bus_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .data_oe    (data_oe),
  .commit     (commit),
  .cs_sync_act(cs_sync_act),
  .cap_addr   (cap_addr),
  .cap_data   (cap_data),
  .evt_set    (evt_set),
  .irq_status (irq_status),
  .irq_enable (irq_enable)
);

// File: tb/cfg_bus_slave_tb.sv
`timescale 1ns/1ps
module cfg_bus_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_sel = 1'b0;
  logic        cs_n = 1'b1;
  logic        strb_a_n = 1'b1;
  logic        strb_b_n = 1'b1;
  logic [15:0] addr = '0;
  logic [31:0] data_i = '0;
  logic [31:0] data_o;
  logic        data_oe;
  logic [31:0] evt_set = '0;
  logic        irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_bus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .strb_a_n(strb_a_n), .strb_b_n(strb_b_n), .addr(addr), .data_i(data_i),
    .data_o(data_o), .data_oe(data_oe), .evt_set(evt_set), .irq_n(irq_n)
  );

  // {mode, address, write data}
  localparam logic [48:0] VEC [0:7] = '{
    {1'b0, 16'h0000, 32'hA5A5_0001},
    {1'b1, 16'h0001, 32'h1234_5678},
    {1'b0, 16'h0002, 32'hFFFF_FFFF},
    {1'b1, 16'h0003, 32'h8000_0001},
    {1'b0, 16'h0004, 32'hDEAD_BEEF},
    {1'b1, 16'h0005, 32'h0F0F_F0F0},
    {1'b0, 16'h0008, 32'h1111_1111},
    {1'b1, 16'h8001, 32'h2222_2222}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic m, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    mode_sel = m; addr = a; cs_n = 1'b0;
    strb_a_n = m ? 1'b0 : 1'b1;
    @(negedge clk);
    strb_b_n = 1'b0; data_i = d;
    repeat (3) @(negedge clk);
    strb_b_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; strb_a_n = 1'b1; data_i = 32'h5A5A_C3C3; addr = 16'h0;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_read(input logic m, input logic [15:0] a,
                          output logic [31:0] v, output logic oe_on, output logic oe_off);
    @(negedge clk);
    mode_sel = m; addr = a; cs_n = 1'b0; strb_a_n = 1'b1;
    @(negedge clk);
    if (m) strb_b_n = 1'b0; else strb_a_n = 1'b0;
    repeat (3) @(negedge clk);
    v = data_o; oe_on = data_oe;
    cs_n = 1'b1; strb_a_n = 1'b1; strb_b_n = 1'b1;
    #0.5;
    oe_off = data_oe;
    @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic on, off;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {31'b0, data_oe}, 32'h0);
    check("R1 irq in reset", {31'b0, irq_n}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(1'b0, 16'h0004, v, on, off);
    check("R1 reg4 zero", v, 32'h0);
    bus_read(1'b1, 16'h0007, v, on, off);
    check("R1 reg7 zero", v, 32'h0);

    // Table walk: write in the vector's mode, read back in both modes.
    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i][48], VEC[i][47:32], VEC[i][31:0]);
      exp = (VEC[i][47:32] < 16'd8) ? VEC[i][31:0] : 32'h0;
      bus_read(VEC[i][48], VEC[i][47:32], v, on, off);
      check(VEC[i][48] ? "R3 R5 dir-mode write/read" : "R2 R4 split-mode write/read", v, exp);
      check("R4 R5 oe during read", {31'b0, on}, 32'h1);
      check("R6 oe released with cs", {31'b0, off}, 32'h0);
      bus_read(!VEC[i][48], VEC[i][47:32], v, on, off);
      check("R8 R4 R5 cross-mode read", v, exp);
    end
    bus_read(1'b0, 16'h0000, v, on, off);
    check("R8 unmapped write did not alias reg0", v, 32'hA5A5_0001);
    bus_read(1'b1, 16'h0001, v, on, off);
    check("R8 unmapped write did not alias reg1", v, 32'h1234_5678);

    // R7: strobes with chip select high.
    @(negedge clk);
    mode_sel = 1'b0; addr = 16'h0001; data_i = 32'hCAFE_0000;
    strb_b_n = 1'b0; strb_a_n = 1'b0;
    @(negedge clk);
    check("R6 no drive with cs high", {31'b0, data_oe}, 32'h0);
    strb_b_n = 1'b1; strb_a_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(1'b0, 16'h0001, v, on, off);
    check("R7 no write with cs high", v, 32'h1234_5678);

    // R11: dir mode, read direction strobe with data present.
    @(negedge clk);
    mode_sel = 1'b1; addr = 16'h0002; cs_n = 1'b0; strb_a_n = 1'b1; data_i = 32'h0;
    @(negedge clk);
    strb_b_n = 1'b0;
    repeat (3) @(negedge clk);
    strb_b_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(1'b0, 16'h0002, v, on, off);
    check("R11 dir-mode read strobe does not write", v, 32'hFFFF_FFFF);
    // R11: split mode, read strobe pulse.
    @(negedge clk);
    mode_sel = 1'b0; addr = 16'h0003; cs_n = 1'b0; data_i = 32'h0;
    @(negedge clk);
    strb_a_n = 1'b0;
    repeat (3) @(negedge clk);
    strb_a_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(1'b1, 16'h0003, v, on, off);
    check("R11 split-mode read strobe does not write", v, 32'h8000_0001);

    // R9 / R10: interrupt status and enable.
    bus_write(1'b0, 16'h0006, 32'h0000_0005);
    check("R10 no status, irq idle", {31'b0, irq_n}, 32'h1);
    @(negedge clk); evt_set = 32'h0000_0006;
    @(negedge clk); evt_set = 32'h0;
    @(negedge clk);
    check("R10 enabled status asserts irq", {31'b0, irq_n}, 32'h0);
    bus_read(1'b1, 16'h0007, v, on, off);
    check("R9 events set status", v, 32'h0000_0006);
    bus_write(1'b1, 16'h0007, 32'h0000_0004);
    bus_read(1'b0, 16'h0007, v, on, off);
    check("R9 write-one clears only that bit", v, 32'h0000_0002);
    check("R10 irq released after clear", {31'b0, irq_n}, 32'h1);
    bus_write(1'b0, 16'h0006, 32'h0000_0002);
    check("R10 enable change asserts irq", {31'b0, irq_n}, 32'h0);
    // R9: set wins when the event lands on the commit cycle.
    @(negedge clk);
    mode_sel = 1'b0; addr = 16'h0007; cs_n = 1'b0;
    @(negedge clk);
    strb_b_n = 1'b0; data_i = 32'h0000_0002;
    repeat (3) @(negedge clk);
    strb_b_n = 1'b1;
    evt_set = 32'h0000_0002;
    repeat (3) @(negedge clk);
    evt_set = 32'h0;
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(1'b0, 16'h0007, v, on, off);
    check("R9 set wins over clear", v, 32'h0000_0002);
    bus_write(1'b1, 16'h0007, 32'hFFFF_FFFF);
    bus_read(1'b1, 16'h0007, v, on, off);
    check("R9 full clear", v, 32'h0);
    check("R10 irq idle after full clear", {31'b0, irq_n}, 32'h1);

    // R1: reset in mid-run.
    @(negedge clk); evt_set = 32'h0000_0002;
    @(negedge clk); evt_set = 32'h0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq cleared by reset", {31'b0, irq_n}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(1'b0, 16'h0004, v, on, off);
    check("R1 reg4 cleared by reset", v, 32'h0);
    bus_read(1'b1, 16'h0006, v, on, off);
    check("R1 reg6 cleared by reset", v, 32'h0);

    summary();
  end
endmodule